// File: doc/BRIEF.md
# One-Wire ROM Search Step Engine

This block sits beside the shift engine of a one-wire bus master. While the search mode input is high, each byte the host writes no longer goes out as eight data slots. It becomes four ROM-search bit steps. Each step reads a device ID bit, then reads its complement, decides which branch to follow, and writes the chosen bit back so that non-matching devices drop out. The results of the four steps come back to the host packed into one received byte.

The host prepares the bus in normal mode: a reset, then the search command byte. It then raises the search mode input and performs sixteen exchanges. Each exchange yields four ROM bits, filled from the least significant nibble upward, so sixteen exchanges cover a 64-bit ID. The discrepancy flags tell the host where the next pass should branch. The slots themselves are produced by an external time-slot generator through a request/done handshake.

Top module: `owsa_core`

## Requirements
- R1: After synchronous reset, rx_full_o is 0, slot_req_o is 0 and rx_byte_o is 0x00.
- R2: A host byte (tx_valid_i) starts an exchange only when acc_en_i is 1 and no exchange is in progress. Otherwise it is ignored: it issues no slot, raises no rx_full_o, and does not alter the direction bits in use.
- R3: Each step uses exactly three slots in the order read, read, write (slot_wr_o = 0, 0, 1), so one exchange uses 4 × 3 = 12 slots.
- R4: When the ID bit and its complement differ, the chosen bit equals the ID bit and the discrepancy flag is 0.
- R5: When both reads are 0, the discrepancy flag is 1 and the chosen bit for step k is bit 2k+1 of the accepted host byte.
- R6: When both reads are 1 (no device responding), the chosen bit is 1 and the discrepancy flag is 1.
- R7: The bit driven in the write slot of each step (slot_wbit_o) equals that step's chosen bit.
- R8: In rx_byte_o, bit 2k+1 holds the chosen bit of step k and bit 2k holds its discrepancy flag. rx_full_o pulses high for exactly one cycle, in the cycle after the fourth write slot completes. rx_byte_o changes only together with that pulse.
- R9: Driving acc_en_i low abandons any exchange. slot_req_o is 0 from the next cycle on, and no rx_full_o pulse follows.
- R10: Sixteen exchanges, each taking bits 2k+1 of the received byte as ROM bits 4i+k, reproduce the 64-bit ID of the device selected by the direction bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_en_i | input | 1 | Search step mode enable |
| tx_valid_i | input | 1 | Host byte write strobe |
| tx_byte_i | input | 8 | Host byte; bit 2k+1 is the branch direction for step k |
| slot_req_o | output | 1 | Requests a time slot from the slot generator |
| slot_wr_o | output | 1 | 1 = write slot, 0 = read slot |
| slot_wbit_o | output | 1 | Bit driven during a write slot |
| slot_done_i | input | 1 | One-cycle pulse ending the current slot |
| slot_rbit_i | input | 1 | Bus value sampled in a read slot, valid with slot_done_i |
| rx_byte_o | output | 8 | Packed step results |
| rx_full_o | output | 1 | One-cycle pulse: rx_byte_o updated |

## Verification
The checker assumes that the slot generator pulses slot_done_i for one cycle, only while slot_req_o is high. It also assumes that slot_rbit_i is meaningful in that cycle and that acc_en_i does not fall in the cycle a done pulse is consumed. The bench's slot generator answers a request after a fixed latency and drops its done pulse on the following edge. It models a wired-AND bus of zero to two devices, with each device leaving the search when a written bit differs from its own. Search mode is lowered only while no done pulse is pending.

// File: rtl/owsa_pkg.sv
package owsa_pkg;
  typedef enum logic [1:0] {
    PH_ID  = 2'd0,
    PH_CMP = 2'd1,
    PH_WR  = 2'd2
  } phase_e;

  typedef struct packed {
    logic chosen;
    logic disc;
  } verdict_t;
endpackage

// File: rtl/owsa_decide.sv
module owsa_decide
  import owsa_pkg::*;
(
  input  logic     id_bit,
  input  logic     cmp_bit,
  input  logic     dir_bit,
  output verdict_t verdict
);
  always_comb begin
    unique case ({id_bit, cmp_bit})
      2'b01:   verdict = '{chosen: 1'b0, disc: 1'b0};
      2'b10:   verdict = '{chosen: 1'b1, disc: 1'b0};
      2'b00:   verdict = '{chosen: dir_bit, disc: 1'b1};
      default: verdict = '{chosen: 1'b1, disc: 1'b1};
    endcase
  end
endmodule

// File: rtl/owsa_seq.sv
module owsa_seq
  import owsa_pkg::*;
#(
  parameter int STEPS = 4,
  localparam int SW = (STEPS > 1) ? $clog2(STEPS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc_en,
  input  logic          tx_valid,
  input  logic          slot_done,
  output logic          slot_req,
  output logic          slot_wr,
  output logic [SW-1:0] step,
  output logic          start,
  output logic          cap_id,
  output logic          cap_cmp,
  output logic          wr_done,
  output logic          fin
);
  localparam logic [SW-1:0] LAST = SW'(STEPS - 1);

  logic   busy;
  phase_e phase;

  assign start   = acc_en && !busy && tx_valid;
  assign cap_id  = acc_en && busy && slot_done && (phase == PH_ID);
  assign cap_cmp = acc_en && busy && slot_done && (phase == PH_CMP);
  assign wr_done = acc_en && busy && slot_done && (phase == PH_WR);
  assign fin     = wr_done && (step == LAST);

  always_ff @(posedge clk) begin
    if (rst || !acc_en) begin
      busy     <= 1'b0;
      phase    <= PH_ID;
      step     <= '0;
      slot_req <= 1'b0;
      slot_wr  <= 1'b0;
    end else if (!busy) begin
      if (tx_valid) begin
        busy     <= 1'b1;
        phase    <= PH_ID;
        step     <= '0;
        slot_req <= 1'b1;
        slot_wr  <= 1'b0;
      end
    end else if (slot_done) begin
      unique case (phase)
        PH_ID: phase <= PH_CMP;
        PH_CMP: begin
          phase   <= PH_WR;
          slot_wr <= 1'b1;
        end
        default: begin
          phase   <= PH_ID;
          slot_wr <= 1'b0;
          if (step == LAST) begin
            busy     <= 1'b0;
            slot_req <= 1'b0;
            step     <= '0;
          end else begin
            step <= step + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/owsa_pack.sv
module owsa_pack
  import owsa_pkg::*;
#(
  parameter int STEPS = 4,
  localparam int SW = (STEPS > 1) ? $clog2(STEPS) : 1,
  localparam int BW = 2 * STEPS
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          wr_done,
  input  logic          fin,
  input  logic [SW-1:0] step,
  input  verdict_t      verdict,
  output logic [BW-1:0] rx_byte,
  output logic          rx_full
);
  logic [BW-1:0] work_q;
  logic [BW-1:0] work_nx;

  for (genvar k = 0; k < STEPS; k++) begin : g_lane
    logic hit;
    assign hit = wr_done && (step == SW'(k));
    assign work_nx[2*k+1] = hit ? verdict.chosen : work_q[2*k+1];
    assign work_nx[2*k]   = hit ? verdict.disc   : work_q[2*k];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      work_q  <= '0;
      rx_byte <= '0;
      rx_full <= 1'b0;
    end else begin
      rx_full <= fin;
      if (start)
        work_q <= '0;
      else
        work_q <= work_nx;
      if (fin)
        rx_byte <= work_nx;
    end
  end
endmodule

// File: rtl/owsa_core.sv
module owsa_core
  import owsa_pkg::*;
#(
  parameter int STEPS = 4,
  localparam int SW = (STEPS > 1) ? $clog2(STEPS) : 1,
  localparam int BW = 2 * STEPS
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc_en_i,
  input  logic          tx_valid_i,
  input  logic [BW-1:0] tx_byte_i,
  output logic          slot_req_o,
  output logic          slot_wr_o,
  output logic          slot_wbit_o,
  input  logic          slot_done_i,
  input  logic          slot_rbit_i,
  output logic [BW-1:0] rx_byte_o,
  output logic          rx_full_o
);
  logic          start, cap_id, cap_cmp, wr_done, fin;
  logic [SW-1:0] step;
  logic [STEPS-1:0] dir_q;
  logic          id_q;
  verdict_t      verdict_now, verdict_q;

  owsa_seq #(.STEPS(STEPS)) seq_i (
    .clk(clk), .rst(rst), .acc_en(acc_en_i), .tx_valid(tx_valid_i),
    .slot_done(slot_done_i), .slot_req(slot_req_o), .slot_wr(slot_wr_o),
    .step(step), .start(start), .cap_id(cap_id), .cap_cmp(cap_cmp),
    .wr_done(wr_done), .fin(fin)
  );

  owsa_decide decide_i (
    .id_bit(id_q), .cmp_bit(slot_rbit_i), .dir_bit(dir_q[step]),
    .verdict(verdict_now)
  );

  owsa_pack #(.STEPS(STEPS)) pack_i (
    .clk(clk), .rst(rst), .start(start), .wr_done(wr_done), .fin(fin),
    .step(step), .verdict(verdict_q), .rx_byte(rx_byte_o), .rx_full(rx_full_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q       <= '0;
      id_q        <= 1'b0;
      verdict_q   <= '0;
      slot_wbit_o <= 1'b0;
    end else begin
      if (start)
        for (int k = 0; k < STEPS; k++)
          dir_q[k] <= tx_byte_i[2*k+1];
      if (cap_id)
        id_q <= slot_rbit_i;
      if (cap_cmp) begin
        verdict_q   <= verdict_now;
        slot_wbit_o <= verdict_now.chosen;
      end
    end
  end
endmodule

// File: rtl/owsa_chk.sv
module owsa_chk #(
  parameter int STEPS = 4,
  localparam int BW = 2 * STEPS,
  localparam int CW = $clog2(STEPS + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          acc_en_i,
  input logic          slot_req_o,
  input logic          slot_wr_o,
  input logic          slot_wbit_o,
  input logic          slot_done_i,
  input logic          slot_rbit_i,
  input logic [BW-1:0] rx_byte_o,
  input logic          rx_full_o
);
  logic [1:0]    hist;
  logic [CW-1:0] wcnt;
  logic          rd_evt, wr_evt;

  assign rd_evt = acc_en_i && slot_req_o && slot_done_i && !slot_wr_o;
  assign wr_evt = acc_en_i && slot_req_o && slot_done_i && slot_wr_o;

  always_ff @(posedge clk) begin
    if (rst || !acc_en_i) begin
      hist <= 2'b00;
      wcnt <= '0;
    end else begin
      if (rd_evt)
        hist <= {hist[0], slot_rbit_i};
      if (wr_evt)
        wcnt <= (wcnt == CW'(STEPS - 1)) ? '0 : wcnt + 1'b1;
    end
  end

  // R6
  no_device_writes_one_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_evt && hist == 2'b11) |-> slot_wbit_o);

  // R4
  unique_branch_follows_id_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_evt && hist[1] != hist[0]) |-> (slot_wbit_o == hist[1]));

  // R8
  rx_full_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    rx_full_o |=> !rx_full_o);

  // R8
  rx_full_after_last_write_chk: assert property (@(posedge clk) disable iff (rst)
    rx_full_o |-> ($past(wr_evt) && wcnt == '0));

  // R8
  rx_byte_only_with_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(rx_byte_o) |-> rx_full_o);

  // R9
  abort_drops_request_chk: assert property (@(posedge clk) disable iff (rst)
    !acc_en_i |=> !slot_req_o);
endmodule

bind owsa_core owsa_chk #(.STEPS(STEPS)) chk_i (
  .clk(clk), .rst(rst), .acc_en_i(acc_en_i), .slot_req_o(slot_req_o),
  .slot_wr_o(slot_wr_o), .slot_wbit_o(slot_wbit_o), .slot_done_i(slot_done_i),
  .slot_rbit_i(slot_rbit_i), .rx_byte_o(rx_byte_o), .rx_full_o(rx_full_o)
);

// File: tb/owsa_core_tb_top.sv
`timescale 1ns/1ps
module owsa_core_tb_top;
  localparam int LAT = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       acc_en = 1'b0;
  logic       tx_valid = 1'b0;
  logic [7:0] tx_byte = 8'h00;
  logic       slot_req, slot_wr, slot_wbit;
  logic       slot_done = 1'b0;
  logic       slot_rbit = 1'b0;
  logic [7:0] rx_byte;
  logic       rx_full;

  always #2 clk = ~clk;

  owsa_core dut_i (
    .clk(clk), .rst(rst), .acc_en_i(acc_en), .tx_valid_i(tx_valid),
    .tx_byte_i(tx_byte), .slot_req_o(slot_req), .slot_wr_o(slot_wr),
    .slot_wbit_o(slot_wbit), .slot_done_i(slot_done), .slot_rbit_i(slot_rbit),
    .rx_byte_o(rx_byte), .rx_full_o(rx_full)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  logic [63:0] rom [4];
  logic        alive [4];
  int          ndev = 0;
  int          bi = 0;
  logic        m_busy = 1'b0;
  int          m_phase = 0;
  int          m_step = 0;
  logic [3:0]  m_dir = 4'h0;
  logic        m_id = 1'b0;
  logic        m_ch = 1'b0;
  logic        m_dc = 1'b0;
  logic [7:0]  m_byte = 8'h00;
  logic        pend_full = 1'b0;
  int          cnt = 0;

  function automatic logic bus_read(input logic want_cmp);
    logic v = 1'b1;
    for (int d = 0; d < ndev; d++)
      if (alive[d]) v &= want_cmp ? ~rom[d][bi] : rom[d][bi];
    return v;
  endfunction

  task automatic fail_msg(input string req, input logic [63:0] act, input logic [63:0] exp);
    errors++;
    $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) fail_msg(req, act, exp);
  endtask

  // Reference model and slot generator, compared on every clock.
  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
    if (!rst) begin
      chk("R8 rx_full timing", 64'(rx_full), 64'(pend_full));
      if (pend_full) begin
        chk("R8 rx_byte layout", 64'(rx_byte), 64'(m_byte));
        m_busy = 1'b0;
      end
      pend_full = 1'b0;
      if (slot_done) begin
        slot_done = 1'b0;
        cnt = 0;
      end else if (!acc_en) begin
        m_busy = 1'b0;  // R9
        cnt = 0;
      end else if (!m_busy) begin
        if (tx_valid) begin
          m_busy = 1'b1; m_phase = 0; m_step = 0; m_byte = 8'h00;
          for (int k = 0; k < 4; k++) m_dir[k] = tx_byte[2*k+1];
        end
      end else if (slot_req) begin
        cnt++;
        if (cnt >= LAT) begin
          chk("R3 slot kind order", 64'(slot_wr), 64'(m_phase == 2));
          if (m_phase == 0) begin
            m_id = bus_read(1'b0);
            slot_rbit = m_id;
          end else if (m_phase == 1) begin
            logic c;
            c = bus_read(1'b1);
            slot_rbit = c;
            if (m_id != c) begin m_ch = m_id; m_dc = 1'b0; end       // R4
            else if (!m_id) begin m_ch = m_dir[m_step]; m_dc = 1'b1; end // R5
            else begin m_ch = 1'b1; m_dc = 1'b1; end                // R6
          end else begin
            chk("R7 written bit", 64'(slot_wbit), 64'(m_ch));
            for (int d = 0; d < ndev; d++)
              if (rom[d][bi] != m_ch) alive[d] = 1'b0;
            bi++;
            m_byte[2*m_step+1] = m_ch;
            m_byte[2*m_step]   = m_dc;
            if (m_step == 3) pend_full = 1'b1;
            else m_step++;
          end
          m_phase = (m_phase + 1) % 3;
          slot_done = 1'b1;
        end
      end
    end
  end

  task automatic send(input logic [7:0] b);
    @(posedge clk); #1;
    tx_valid = 1'b1; tx_byte = b;
    @(posedge clk); #1;
    tx_valid = 1'b0;
  endtask

  task automatic wait_rx(output logic [7:0] b);
    b = 8'h00;
    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      if (rx_full) begin b = rx_byte; return; end
    end
    fail_msg("R8 rx_full never seen", 0, 1);
  endtask

  task automatic search(input logic [7:0] dir, output logic [63:0] id, output logic [63:0] disc);
    logic [7:0] b;
    @(posedge clk); #1;
    bi = 0;
    for (int d = 0; d < 4; d++) alive[d] = 1'b1;
    id = '0; disc = '0;
    for (int i = 0; i < 16; i++) begin
      send(dir);
      wait_rx(b);
      for (int k = 0; k < 4; k++) begin
        id[4*i+k]   = b[2*k+1];
        disc[4*i+k] = b[2*k];
      end
    end
  endtask

  initial begin
    logic [63:0] id, disc;
    logic [7:0]  b;
    int          seen;
    rom[0] = 64'hA5C3_1F00_7E92_4B18;
    rom[1] = 64'hA5C3_1F00_7E92_4B08;
    rom[2] = '0; rom[3] = '0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1
    chk("R1 rx_full reset", 64'(rx_full), 0);
    chk("R1 slot_req reset", 64'(slot_req), 0);
    chk("R1 rx_byte reset", 64'(rx_byte), 0);

    // R2: byte written outside search mode is ignored
    send(8'hAA);
    seen = 0;
    for (int n = 0; n < 30; n++) begin @(negedge clk); seen += slot_req; end
    chk("R2 no slots when search off", 64'(seen), 0);

    acc_en = 1'b1;
    // R4, R10: single device, no discrepancies
    ndev = 1;
    search(8'h00, id, disc);
    chk("R10 single device id", id, rom[0]);
    chk("R4 no discrepancies", disc, 0);

    // R5: two devices differing at bit 4, direction 1 then 0
    ndev = 2;
    search(8'hAA, id, disc);
    chk("R5 dir=1 selects device with 1", id, rom[0]);
    chk("R5 discrepancy position", disc, 64'h10);
    search(8'h00, id, disc);
    chk("R5 dir=0 selects device with 0", id, rom[1]);
    chk("R5 discrepancy position dir0", disc, 64'h10);

    // R6: no devices
    ndev = 0;
    search(8'h00, id, disc);
    chk("R6 no device chosen bits", id, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R6 no device flags", disc, 64'hFFFF_FFFF_FFFF_FFFF);

    // R2: byte written mid exchange is ignored
    ndev = 2;
    @(posedge clk); #1;
    bi = 0; alive[0] = 1'b1; alive[1] = 1'b1;
    send(8'h00);
    repeat (4) @(posedge clk);
    send(8'hFF);
    seen = 0;
    for (int n = 0; n < 120; n++) begin @(negedge clk); seen += rx_full; end
    chk("R2 busy write ignored, single pulse", 64'(seen), 1);

    // R9: abort mid exchange
    send(8'h00);
    repeat (10) @(posedge clk);
    #1 acc_en = 1'b0;
    @(negedge clk); @(negedge clk);
    seen = 0;
    for (int n = 0; n < 60; n++) begin @(negedge clk); seen += slot_req + rx_full; end
    chk("R9 abort quiet", 64'(seen), 0);
    acc_en = 1'b1;

    // After abort the block works again
    ndev = 1;
    search(8'h00, id, disc);
    chk("R10 id after abort", id, rom[0]);
    b = rx_byte;
    repeat (5) @(negedge clk);
    chk("R8 rx_byte holds", 64'(rx_byte), 64'(b));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule